// File: doc/BRIEF.md
# Split-Mode Integer Multiplier

This block multiplies two 16-bit operand words. In wide mode it forms one 16x16 product of 32 bits. In paired mode the same partial-product array yields two separate 8x8 products of 16 bits each, packed side by side in the 32-bit result. A per-operation flag picks two's-complement or unsigned operands. A second flag rounds each product to its upper half, with the lower half cleared.

Each operation comes with a valid strobe. The block accepts a new operation on every clock. The result and its own valid strobe appear exactly two clock edges later. The first stage registers the four byte-by-byte partial products, each sign- or zero-extended to nine bits. The second stage combines or packs them, applies rounding and registers the result.

The operation kind is an enumeration with four values: `K_WIDE`, `K_WIDE_RND`, `K_PAIR` and `K_PAIR_RND`. It is decoded from the split and round flags and travels down the pipeline with the data. The pipeline has no control states beyond the two valid bits. A stage is filled when its valid bit is set and keeps its data when that bit is clear.

Top module: `smul_top`

## Requirements
- R1: With `in_split`=1, the product of bits 7:0 of both operands appears in `out_prod[15:0]`, and the product of bits 15:8 of both operands appears in `out_prod[31:16]`. Neither lane depends on the other lane's bytes.
- R2: With `in_split`=0, `out_prod` is the 32-bit product of the two full 16-bit operands.
- R3: With `in_sgn`=1, operands are two's complement: each byte in paired mode, and each whole word in wide mode. Results are two's complement.
- R4: With `in_sgn`=0, operands and results are unsigned.
- R5: With `in_rnd`=1 and `in_split`=0, the result is (P + 0x8000) mod 2^32 with bits 15:0 cleared, where P is the 32-bit product.
- R6: With `in_rnd`=1 and `in_split`=1, each 16-bit lane is (p + 0x80) mod 2^16 with its bits 7:0 cleared, where p is that lane's product.
- R7: `out_vld` rises exactly two clock edges after an operation is sampled with `in_vld`=1. The matching product is on `out_prod` in the same cycle. Back-to-back operations come out in order, one per cycle.
- R8: While `rst` is high at a clock edge, `out_vld` and `out_prod` are cleared to zero.
- R9: `out_prod` keeps its last value whenever `out_vld` is low. Operand inputs with `in_vld`=0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operation valid this cycle |
| in_a | input | 16 | First operand word |
| in_b | input | 16 | Second operand word |
| in_split | input | 1 | 1 = two packed 8x8 products, 0 = one 16x16 product |
| in_sgn | input | 1 | 1 = two's complement operands, 0 = unsigned |
| in_rnd | input | 1 | 1 = round to the upper half of each product |
| out_vld | output | 1 | Result valid |
| out_prod | output | 32 | Product or packed product pair |

## Verification
Every combination of split, sign and round flags is streamed with operand bytes drawn from a set of eight values: zero, one, both signed extremes, the value just past the negative extreme, all ones, and two mixed bit patterns. Every pairing of these bytes across all four byte positions is used, so cross-byte terms that would leak into the wrong lane show up in paired mode. The extremes separate a sign-extension fault from a zero-extension fault. The all-ones and extreme products make a rounding carry ripple into the upper half. Idle cycles with changing operands are placed in the stream to show that the hold behaviour and one-per-cycle ordering survive gaps. A lone operation surrounded by idle cycles pins down the exact two-edge latency.

// File: rtl/smul_pkg.sv
package smul_pkg;

    typedef enum logic [1:0] {
        K_WIDE     = 2'd0,
        K_WIDE_RND = 2'd1,
        K_PAIR     = 2'd2,
        K_PAIR_RND = 2'd3
    } smul_kind_e;

    function automatic smul_kind_e kind_of(input logic split, input logic rnd);
        smul_kind_e k;
        unique case ({split, rnd})
            2'b00:   k = K_WIDE;
            2'b01:   k = K_WIDE_RND;
            2'b10:   k = K_PAIR;
            default: k = K_PAIR_RND;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/smul_partial.sv
module smul_partial #(
    parameter int LANE_W = 8,
    localparam int OP_W = 2 * LANE_W,
    localparam int PP_W = 2 * (LANE_W + 1)
) (
    input  logic [OP_W-1:0]      a_i,
    input  logic [OP_W-1:0]      b_i,
    input  logic                 split_i,
    input  logic                 sgn_i,
    output logic [3:0][PP_W-1:0] pp_o
);

    // Each byte gets a ninth bit. The upper byte is signed whenever sgn_i is set.
    // The lower byte is signed only in paired mode, because in wide mode it is
    // the unsigned low half of a wider number.
    logic [1:0][LANE_W:0] a_x;
    logic [1:0][LANE_W:0] b_x;

    for (genvar i = 0; i < 2; i++) begin : g_ext
        logic ext_en;
        if (i == 0) begin : g_lo
            assign ext_en = sgn_i & split_i;
        end else begin : g_hi
            assign ext_en = sgn_i;
        end
        assign a_x[i] = {ext_en & a_i[i*LANE_W+LANE_W-1], a_i[i*LANE_W +: LANE_W]};
        assign b_x[i] = {ext_en & b_i[i*LANE_W+LANE_W-1], b_i[i*LANE_W +: LANE_W]};
    end

    // Index 2*i+j holds the product of a byte i and b byte j.
    for (genvar i = 0; i < 2; i++) begin : g_row
        for (genvar j = 0; j < 2; j++) begin : g_col
            logic signed [PP_W-1:0] sa;
            logic signed [PP_W-1:0] sb;
            assign sa = PP_W'($signed(a_x[i]));
            assign sb = PP_W'($signed(b_x[j]));
            assign pp_o[2*i+j] = sa * sb;
        end
    end

endmodule

// File: rtl/smul_assemble.sv
module smul_assemble
    import smul_pkg::*;
#(
    parameter int LANE_W = 8,
    localparam int OP_W  = 2 * LANE_W,
    localparam int RES_W = 4 * LANE_W,
    localparam int PP_W  = 2 * (LANE_W + 1)
) (
    input  logic [3:0][PP_W-1:0] pp_i,
    input  smul_kind_e           kind_i,
    output logic [RES_W-1:0]     res_o
);

    localparam logic [RES_W-1:0] WIDE_HALF = RES_W'(1) << (OP_W - 1);
    localparam logic [RES_W-1:0] WIDE_MASK = {{OP_W{1'b1}}, {OP_W{1'b0}}};
    localparam logic [OP_W-1:0]  LANE_HALF = OP_W'(1) << (LANE_W - 1);
    localparam logic [OP_W-1:0]  LANE_MASK = {{LANE_W{1'b1}}, {LANE_W{1'b0}}};

    // Wide mode: weighted sum of the four sign-extended partial products.
    logic [3:0][RES_W-1:0] wx;
    for (genvar k = 0; k < 4; k++) begin : g_wext
        assign wx[k] = RES_W'($signed(pp_i[k]));
    end

    logic [RES_W-1:0] wide_sum;
    logic [RES_W-1:0] wide_rnd;
    assign wide_sum = wx[0]
                    + (wx[1] << LANE_W)
                    + (wx[2] << LANE_W)
                    + (wx[3] << OP_W);
    assign wide_rnd = (wide_sum + WIDE_HALF) & WIDE_MASK;

    // Paired mode: lane 0 takes the low-byte product, lane 1 the high-byte product.
    logic [1:0][OP_W-1:0] lane_raw;
    logic [1:0][OP_W-1:0] lane_rnd;
    assign lane_raw[0] = pp_i[0][OP_W-1:0];
    assign lane_raw[1] = pp_i[3][OP_W-1:0];

    for (genvar k = 0; k < 2; k++) begin : g_lane
        assign lane_rnd[k] = (lane_raw[k] + LANE_HALF) & LANE_MASK;
    end

    always_comb begin
        unique case (kind_i)
            K_WIDE:     res_o = wide_sum;
            K_WIDE_RND: res_o = wide_rnd;
            K_PAIR:     res_o = lane_raw;
            K_PAIR_RND: res_o = lane_rnd;
            default:    res_o = '0;
        endcase
    end

endmodule

// File: rtl/smul_top.sv
module smul_top
    import smul_pkg::*;
#(
    parameter int LANE_W = 8,
    localparam int OP_W  = 2 * LANE_W,
    localparam int RES_W = 4 * LANE_W,
    localparam int PP_W  = 2 * (LANE_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic [OP_W-1:0]  in_a,
    input  logic [OP_W-1:0]  in_b,
    input  logic             in_split,
    input  logic             in_sgn,
    input  logic             in_rnd,
    output logic             out_vld,
    output logic [RES_W-1:0] out_prod
);

    logic [3:0][PP_W-1:0] pp_now;
    logic [3:0][PP_W-1:0] s1_pp;
    smul_kind_e           s1_kind;
    logic                 s1_vld;
    logic [RES_W-1:0]     asm_res;

    smul_partial #(.LANE_W(LANE_W)) u_partial (
        .a_i     (in_a),
        .b_i     (in_b),
        .split_i (in_split),
        .sgn_i   (in_sgn),
        .pp_o    (pp_now)
    );

    // Stage one: partial products and operation kind.
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld  <= 1'b0;
            s1_pp   <= '0;
            s1_kind <= K_WIDE;
        end else begin
            s1_vld <= in_vld;
            if (in_vld) begin
                s1_pp   <= pp_now;
                s1_kind <= kind_of(in_split, in_rnd);
            end
        end
    end

    smul_assemble #(.LANE_W(LANE_W)) u_assemble (
        .pp_i   (s1_pp),
        .kind_i (s1_kind),
        .res_o  (asm_res)
    );

    // Stage two: the registered result.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_prod <= '0;
        end else begin
            out_vld <= s1_vld;
            if (s1_vld) begin
                out_prod <= asm_res;
            end
        end
    end

    // Counts edges since reset so that two-edge look-backs stay inside history.
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst) begin
            warm <= 2'd0;
        end else if (warm != 2'd2) begin
            warm <= warm + 2'd1;
        end
    end

    assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2) |-> (out_vld == $past(in_vld, 2)));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2 && !$past(in_vld, 2)) |-> $stable(out_prod));

    assert_wide_round_low_R5: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2 && out_vld && $past(in_vld && in_rnd && !in_split, 2))
        |-> (out_prod[OP_W-1:0] == '0));

    assert_pair_round_low_R6: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2 && out_vld && $past(in_vld && in_rnd && in_split, 2))
        |-> (out_prod[LANE_W-1:0] == '0 && out_prod[OP_W +: LANE_W] == '0));

    assert_lane_isolated_R1: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2 && out_vld && $past(in_vld && in_split && in_a[LANE_W-1:0] == '0, 2))
        |-> (out_prod[OP_W-1:0] == '0));

    assert_wide_unit_R2: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd2 && out_vld
            && $past(in_vld && !in_split && !in_rnd && in_b == OP_W'(1), 2))
        |-> (out_prod == ($past(in_sgn, 2) ? RES_W'($signed($past(in_a, 2)))
                                           : RES_W'($past(in_a, 2)))));

endmodule

// File: tb/tb_smul_top.sv
`timescale 1ns/1ps
module tb_smul_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_vld;
    logic [15:0] in_a;
    logic [15:0] in_b;
    logic        in_split;
    logic        in_sgn;
    logic        in_rnd;
    logic        out_vld;
    logic [31:0] out_prod;

    int total = 0;
    int bad   = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] last_out;

    always #2.5 clk = ~clk;

    smul_top dut (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (in_vld),
        .in_a     (in_a),
        .in_b     (in_b),
        .in_split (in_split),
        .in_sgn   (in_sgn),
        .in_rnd   (in_rnd),
        .out_vld  (out_vld),
        .out_prod (out_prod)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [15:0] a, input logic [15:0] b,
                                          input logic sp, input logic sg, input logic rd);
        longint xa;
        longint xb;
        longint p;
        logic [15:0] l0;
        logic [15:0] l1;
        logic [31:0] r;
        if (sp) begin
            xa = sg ? longint'($signed(a[7:0])) : longint'(a[7:0]);
            xb = sg ? longint'($signed(b[7:0])) : longint'(b[7:0]);
            p  = xa * xb;
            l0 = p[15:0];
            xa = sg ? longint'($signed(a[15:8])) : longint'(a[15:8]);
            xb = sg ? longint'($signed(b[15:8])) : longint'(b[15:8]);
            p  = xa * xb;
            l1 = p[15:0];
            if (rd) begin
                l0 = (l0 + 16'h0080) & 16'hFF00;
                l1 = (l1 + 16'h0080) & 16'hFF00;
            end
            r = {l1, l0};
        end else begin
            xa = sg ? longint'($signed(a)) : longint'(a);
            xb = sg ? longint'($signed(b)) : longint'(b);
            p  = xa * xb;
            r  = p[31:0];
            if (rd) r = (r + 32'h0000_8000) & 32'hFFFF_0000;
        end
        return r;
    endfunction

    function automatic logic [7:0] bv(input logic [2:0] k);
        logic [7:0] v;
        case (k)
            3'd0: v = 8'h00;
            3'd1: v = 8'h01;
            3'd2: v = 8'h7F;
            3'd3: v = 8'h80;
            3'd4: v = 8'h81;
            3'd5: v = 8'hFF;
            3'd6: v = 8'h55;
            default: v = 8'hA6;
        endcase
        return v;
    endfunction

    function automatic string tag_of(input logic sp, input logic sg, input logic rd);
        string m;
        m = sp ? (rd ? "R6" : "R1") : (rd ? "R5" : "R2");
        return $sformatf("%s/%s", m, sg ? "R3" : "R4");
    endfunction

    // Compare what left the pipeline at this point, before new inputs go in.
    task automatic observe();
        if (out_vld) begin
            if (exp_q.size() == 0) begin
                chk("R7 unexpected result", {31'd0, out_vld}, 32'd0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, out_prod, e);
                last_out = e;
            end
        end else begin
            chk("R9 hold while idle", out_prod, last_out);
        end
    endtask

    task automatic step(input logic v, input logic [15:0] a, input logic [15:0] b,
                        input logic sp, input logic sg, input logic rd);
        @(negedge clk);
        observe();
        in_vld   = v;
        in_a     = a;
        in_b     = b;
        in_split = sp;
        in_sgn   = sg;
        in_rnd   = rd;
        if (v) begin
            exp_q.push_back(model(a, b, sp, sg, rd));
            tag_q.push_back(tag_of(sp, sg, rd));
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R7 watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst      = 1'b1;
        in_vld   = 1'b1;
        in_a     = 16'hFFFF;
        in_b     = 16'hFFFF;
        in_split = 1'b0;
        in_sgn   = 1'b0;
        in_rnd   = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: cleared while reset is held, even with a valid operation present.
        chk("R8 out_vld in reset", {31'd0, out_vld}, 32'd0);
        chk("R8 out_prod in reset", out_prod, 32'd0);
        in_vld   = 1'b0;
        rst      = 1'b0;
        last_out = 32'd0;

        // R7: a lone operation between idle cycles.
        @(negedge clk);
        in_vld = 1'b1; in_a = 16'hFF85; in_b = 16'h0013;
        in_split = 1'b0; in_sgn = 1'b1; in_rnd = 1'b0;
        @(negedge clk);
        chk("R7 no result after one edge", {31'd0, out_vld}, 32'd0);
        in_vld = 1'b0; in_a = 16'h1234; in_b = 16'h5678;
        @(negedge clk);
        chk("R7 valid after two edges", {31'd0, out_vld}, 32'd1);
        chk("R7/R2/R3 lone product", out_prod, model(16'hFF85, 16'h0013, 1'b0, 1'b1, 1'b0));
        last_out = out_prod;
        in_a = 16'hAAAA; in_b = 16'h5555; in_split = 1'b1; in_rnd = 1'b1;
        @(negedge clk);
        chk("R7 single valid pulse", {31'd0, out_vld}, 32'd0);
        chk("R9 held after idle operands", out_prod, last_out);
        repeat (3) step(1'b0, 16'hBEEF, 16'hCAFE, 1'b1, 1'b0, 1'b1);

        // Sweep every flag combination over all pairings of the byte set.
        for (int m = 0; m < 8; m++) begin
            for (int idx = 0; idx < 4096; idx++) begin
                logic [11:0] ix;
                logic [15:0] a;
                logic [15:0] b;
                ix = 12'(idx);
                a = {bv(ix[11:9]), bv(ix[8:6])};
                b = {bv(ix[5:3]), bv(ix[2:0])};
                if (idx % 13 == 12) begin
                    step(1'b0, ~a, b ^ 16'h3C3C, ~m[0], ~m[1], ~m[2]);
                end
                step(1'b1, a, b, m[0], m[1], m[2]);
            end
        end
        repeat (4) step(1'b0, 16'h0F0F, 16'hF0F0, 1'b0, 1'b0, 1'b0);
        chk("R7 every result delivered", 32'(exp_q.size()), 32'd0);
        finish_run();
    end

endmodule